// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

This block computes y = A·v for a small square matrix A and a vector v, using a linear chain of multiply-accumulate cells. Each cell holds one element of v. A load strobe writes all of v into the cells in one clock. Each cell has its own column input for matrix elements. A row's partial sum starts at zero at the left end of the chain and moves one cell to the right on each clock. In every cell it picks up the product of that cell's vector element and the matrix element sitting on the cell's column input at that moment.

The caller feeds the matrix with a diagonal skew. Element a[i][k] is presented on column k exactly k cycles after a[i][0] is presented on column 0. Every position that holds no element is driven with zero. A row-start pulse goes in with each row's first element. It travels with the partial sum, so the right edge delivers one finished dot product per cycle, flagged by a valid signal. Rows can be fed back to back. After a load, one vector can serve any number of row batches.

Top module: `smv_matvec`

## Requirements
- R1: While reset is held, and after it is released, `y_valid` is low, `y_data` is zero and every stored vector element is zero. A batch streamed before any load therefore yields all-zero results.
- R2: A clock edge with `vec_load` high captures every vector element at once. Element k comes from bits [k*DATA_W +: DATA_W] of `vec_in`. Each element is then held unchanged until the next edge with `vec_load` high.
- R3: Each cell registers, on every clock, its left input plus the signed product of its column input and its stored vector element. The left input of cell 0 is zero. The output of the last cell is `y_data`.
- R4: Suppose row i's element for column k is presented k cycles after its column-0 element, and zero is presented everywhere else. Then `y_data` shows the signed dot product of row i with v. It appears in the cycle after the (N-1)th edge following the edge that sampled the column-0 element. For N=3, a 3-row matrix with its first row sampled at edge 1 finishes after edge 5.
- R5: `y_valid` is high in exactly the cycles that follow, by that same latency of N-1 edges, an edge that sampled `row_start` high. It is low in all other cycles.
- R6: Rows fed in consecutive cycles produce results in consecutive cycles, in row order, with no mixing between neighbouring rows. Gaps between batches produce no extra valid results.
- R7: All arithmetic is two's complement. The result width is 2*DATA_W + ceil(log2 N) bits. With every operand at its most negative value, or at the most negative value against the most positive, the result is exact and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vec_load | input | 1 | Load strobe: captures all vector elements on this edge |
| vec_in | input | N_CELLS*DATA_W | Vector elements, element k in bits [k*DATA_W +: DATA_W], signed |
| col_in | input | N_CELLS*DATA_W | Skewed matrix element for each cell, cell k in bits [k*DATA_W +: DATA_W], signed, zero when unused |
| row_start | input | 1 | High with the column-0 element of each row |
| y_data | output | 2*DATA_W+$clog2(N_CELLS) | Dot product of one row with the vector, signed |
| y_valid | output | 1 | Marks the cycles in which y_data holds a row result |

## Verification
A corrupted stored vector element shows up as a wrong value in every result after the load. The error equals that element's error times the matrix entries of its column, so only rows with a zero in that column can hide it. A wrong partial-sum register or a broken link between cells damages a result within N-1 cycles of the fault, and the damage can spill into the neighbouring row. A fault in the valid chain shows up at once as a result flagged one cycle early or late, or as an extra flag during a gap between batches. The mixed stimulus covers all of these: back-to-back rows, single rows, reloads between batches and extreme signed values.

// File: rtl/smv_pkg.sv
package smv_pkg;

  // Width that holds N signed products of two DATA_W operands without wrap.
  function automatic int smv_acc_w(input int data_w, input int n_cells);
    return 2 * data_w + $clog2(n_cells);
  endfunction

  // Number of flops in the reset release chain.
  localparam int SMV_RST_STAGES = 2;

endpackage

// File: rtl/smv_rst_sync.sv
module smv_rst_sync #(
  parameter int STAGES = smv_pkg::SMV_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/smv_coef_reg.sv
module smv_coef_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] coef_in,
  output logic [DATA_W-1:0] coef_out
);

  logic [DATA_W-1:0] coef_q;
  logic [DATA_W-1:0] coef_d;

  always_comb begin
    coef_d = coef_q;
    if (load_en) coef_d = coef_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= '0;
    else        coef_q <= coef_d;
  end

  assign coef_out = coef_q;

  // R2: a load edge captures the presented element
  p_coef_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (coef_out == $past(coef_in)));

  // R2: without a load the element is held
  p_coef_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(coef_out));

endmodule

// File: rtl/smv_mac_stage.sv
module smv_mac_stage #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DATA_W-1:0] elem_in,
  input  logic [DATA_W-1:0] coef,
  input  logic [ACC_W-1:0]  sum_in,
  input  logic              vld_in,
  output logic [ACC_W-1:0]  sum_out,
  output logic              vld_out
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic        [ACC_W-1:0]  sum_d;
  logic        [ACC_W-1:0]  sum_q;
  logic                     vld_q;
  logic        [ACC_W:0]    wide_sum;

  always_comb begin
    prod     = $signed(elem_in) * $signed(coef);
    prod_ext = ACC_W'(prod);
    sum_d    = sum_in + prod_ext;
    wide_sum = {sum_in[ACC_W-1], sum_in} + {prod_ext[ACC_W-1], prod_ext};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      vld_q <= vld_in;
    end
  end

  assign sum_out = sum_q;
  assign vld_out = vld_q;

  // R7: the accumulation never leaves the signed result range
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wide_sum[ACC_W] == wide_sum[ACC_W-1]);

endmodule

// File: rtl/smv_matvec.sv
module smv_matvec #(
  parameter int N_CELLS = 3,
  parameter int DATA_W  = 8,
  parameter int ACC_W   = smv_pkg::smv_acc_w(DATA_W, N_CELLS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vec_load,
  input  logic [N_CELLS*DATA_W-1:0] vec_in,
  input  logic [N_CELLS*DATA_W-1:0] col_in,
  input  logic                      row_start,
  output logic [ACC_W-1:0]          y_data,
  output logic                      y_valid
);

  logic                rst_n_s;
  logic [ACC_W-1:0]    sum_link [0:N_CELLS];
  logic                vld_link [0:N_CELLS];
  logic [DATA_W-1:0]   coef_w   [0:N_CELLS-1];

  smv_rst_sync #(
    .STAGES (smv_pkg::SMV_RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign sum_link[0] = '0;
  assign vld_link[0] = row_start;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    smv_coef_reg #(
      .DATA_W (DATA_W)
    ) u_coef (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .load_en  (vec_load),
      .coef_in  (vec_in[k*DATA_W +: DATA_W]),
      .coef_out (coef_w[k])
    );

    smv_mac_stage #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
    ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .elem_in (col_in[k*DATA_W +: DATA_W]),
      .coef    (coef_w[k]),
      .sum_in  (sum_link[k]),
      .vld_in  (vld_link[k]),
      .sum_out (sum_link[k+1]),
      .vld_out (vld_link[k+1])
    );

    // R5: a row flag leaves a cell only one edge after it entered
    p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
      vld_link[k+1] |-> $past(vld_link[k]));

    // R5: a row flag entering a cell always emerges on the next edge
    p_valid_lands_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
      vld_link[k] |=> vld_link[k+1]);
  end

  assign y_data  = sum_link[N_CELLS];
  assign y_valid = vld_link[N_CELLS];

endmodule

// File: tb/smv_matvec_tb_top.sv
module smv_matvec_tb_top;

  localparam int N      = 3;
  localparam int W      = 8;
  localparam int ACC_W  = 2 * W + $clog2(N);
  localparam int MAXR   = 16;
  localparam int QD     = 1024;

  logic                clk;
  logic                rst_n;
  logic                vec_load;
  logic [N*W-1:0]      vec_in;
  logic [N*W-1:0]      col_in;
  logic                row_start;
  logic [ACC_W-1:0]    y_data;
  logic                y_valid;

  int checks;
  int fails;
  int cyc;
  bit done;

  int mat [0:MAXR-1][0:N-1];
  int vec [0:N-1];

  longint exp_val [0:QD-1];
  int     exp_cyc [0:QD-1];
  int     wr_ptr;
  int     rd_ptr;

  smv_matvec #(.N_CELLS(N), .DATA_W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_load  (vec_load),
    .vec_in    (vec_in),
    .col_in    (col_in),
    .row_start (row_start),
    .y_data    (y_data),
    .y_valid   (y_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint dot_row(input int r);
    longint acc = 0;
    for (int k = 0; k < N; k++) acc += longint'(mat[r][k]) * longint'(vec[k]);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // result monitor: value (R3, R4) and arrival cycle (R5)
  always @(negedge clk) begin
    if (rst_n && y_valid && !done) begin
      if (rd_ptr == wr_ptr) begin
        check(1'b0, "R5 spurious valid", 1, 0);
      end else begin
        check(longint'($signed(y_data)) == exp_val[rd_ptr % QD], "R4 result value",
              longint'($signed(y_data)), exp_val[rd_ptr % QD]);
        check(cyc == exp_cyc[rd_ptr % QD], "R5 result cycle",
              cyc, exp_cyc[rd_ptr % QD]);
        rd_ptr++;
      end
    end
  end

  task automatic load_vector();
    @(negedge clk);
    for (int k = 0; k < N; k++) vec_in[k*W +: W] = W'(vec[k]);
    vec_load = 1'b1;
    @(negedge clk);
    vec_load = 1'b0;
    vec_in   = '0;
  endtask

  // skewed feed of rows 0..nrows-1 of mat, with zero padding (R4, R6)
  task automatic run_batch(input int nrows);
    for (int c = 0; c < nrows + N - 1; c++) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        int r = c - k;
        col_in[k*W +: W] = (r >= 0 && r < nrows) ? W'(mat[r][k]) : '0;
      end
      row_start = (c < nrows);
      if (c < nrows) begin
        exp_val[wr_ptr % QD] = dot_row(c);
        exp_cyc[wr_ptr % QD] = cyc + N;
        wr_ptr++;
      end
    end
    @(negedge clk);
    col_in    = '0;
    row_start = 1'b0;
    repeat (N + 2) @(negedge clk);
    check(rd_ptr == wr_ptr, "R6 all rows delivered", rd_ptr, wr_ptr);
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(2**W - 1)) - 2**(W-1);
  endfunction

  initial begin
    done      = 1'b0;
    checks    = 0;
    fails     = 0;
    cyc       = 0;
    wr_ptr    = 0;
    rd_ptr    = 0;
    rst_n     = 1'b0;
    vec_load  = 1'b0;
    vec_in    = '0;
    col_in    = '0;
    row_start = 1'b0;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    check(y_valid == 1'b0, "R1 valid low in reset", y_valid, 0);
    check(y_data == '0, "R1 data zero in reset", y_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(y_valid == 1'b0, "R1 valid low after reset", y_valid, 0);

    // R1: no load yet, stored elements are zero
    for (int k = 0; k < N; k++) vec[k] = 0;
    for (int r = 0; r < N; r++) for (int k = 0; k < N; k++) mat[r][k] = rnd_s();
    run_batch(N);

    // R4: the 3x3 case with small values
    vec[0] = 2; vec[1] = -3; vec[2] = 5;
    load_vector();
    for (int r = 0; r < N; r++) for (int k = 0; k < N; k++) mat[r][k] = r * N + k + 1;
    run_batch(N);

    // R3: identity matrix returns the vector itself
    for (int r = 0; r < N; r++) for (int k = 0; k < N; k++) mat[r][k] = (r == k) ? 1 : 0;
    run_batch(N);

    // R7: extreme operands
    for (int k = 0; k < N; k++) vec[k] = -(2**(W-1));
    load_vector();
    for (int r = 0; r < 2; r++) for (int k = 0; k < N; k++)
      mat[r][k] = (r == 0) ? -(2**(W-1)) : 2**(W-1) - 1;
    run_batch(2);

    // R6: single row, then long back-to-back batch
    vec[0] = 7; vec[1] = 0; vec[2] = -1;
    load_vector();
    for (int k = 0; k < N; k++) mat[0][k] = rnd_s();
    run_batch(1);
    for (int r = 0; r < MAXR; r++) for (int k = 0; k < N; k++) mat[r][k] = rnd_s();
    run_batch(MAXR);

    // R2: held vector serves a second batch without reload
    for (int r = 0; r < 5; r++) for (int k = 0; k < N; k++) mat[r][k] = rnd_s();
    run_batch(5);

    // random mix of reloads and batch sizes
    for (int t = 0; t < 40; t++) begin
      if ($urandom_range(1) == 1) begin
        for (int k = 0; k < N; k++) vec[k] = rnd_s();
        load_vector();
      end
      begin
        int nr = int'($urandom_range(MAXR - 1)) + 1;
        for (int r = 0; r < nr; r++) for (int k = 0; k < N; k++) mat[r][k] = rnd_s();
        run_batch(nr);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule